// File: doc/BRIEF.md
# Read-Modify-Write Shift Unit

This block sequences a read-modify-write on a single byte in memory for an 8-bit accumulator-style processor. Address generation has already happened by the time it is started. The block then does four things in order:

- it reads the operand at that address;
- it applies one of four shift or rotate operations;
- it writes the result back to the same address;
- it updates the carry, zero and negative flags.

A per-operation mode input selects between two bus behaviours. In the legacy mode an extra write of the unmodified operand precedes the result write. In the modern mode only the result write is issued.

The memory port is simple and synchronous. A one-cycle read strobe returns data on the read-data input in the following cycle, and a one-cycle write strobe stores the write data at the clock edge that ends the cycle. A request is launched with a start pulse, and completion is signalled by a one-cycle done pulse. The flags stay registered until the next operation finishes.

Top module: `rmw_shift_seq`

## Requirements
- R1: During reset, and from any state once reset is asserted, the unit is idle. It drives no read or write strobe, done is low, and carry, zero and negative are all 0.
- R2: Operation code 2'b00 (shift left) produces the operand shifted up by one with 0 in bit 0. Carry becomes the operand's bit 7.
- R3: Operation code 2'b01 (logical shift right) produces the operand shifted down by one with 0 in bit 7. Carry becomes the operand's bit 0.
- R4: Operation code 2'b10 (rotate left) puts the incoming carry input into bit 0. Carry becomes the operand's bit 7.
- R5: Operation code 2'b11 (rotate right) puts the incoming carry input into bit 7. Carry becomes the operand's bit 0.
- R6: Zero is 1 exactly when the 8-bit result is 0x00. Negative equals bit 7 of the result.
- R7: With the legacy mode input at 1, the accesses are issued in this order: one read, then a write of the unmodified operand, then a write of the result, all to the same address. Done is high 5 cycles after the cycle in which start was sampled.
- R8: With the legacy mode input at 0, the read is followed by exactly one write, which carries the result. Done is high 4 cycles after the cycle in which start was sampled.
- R9: Done is high for exactly one cycle, in the cycle right after the final write. The flags are valid in that cycle and hold their values after it.
- R10: Read and write strobes are never high together. A read strobe lasts one cycle. Every access uses the address sampled at start.
- R11: The address, operation code, mode and carry inputs are sampled only in the cycle that start is accepted. A start while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches an operation when the unit is idle |
| op_i | input | 2 | Operation code: 00 shift left, 01 shift right, 10 rotate left, 11 rotate right |
| legacy_bus_i | input | 1 | 1 selects the bus sequence with the extra unmodified write |
| carry_i | input | 1 | Incoming carry used by the rotates |
| addr_i | input | ADDR_W | Resolved operand address |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_re_o | output | 1 | Read strobe; data is returned the next cycle |
| mem_rdata_i | input | 8 | Read data |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| carry_o | output | 1 | Carry flag |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |

## Verification
The assertions assume that the memory returns read data exactly one cycle after the read strobe. They also assume that reset is only released between clock edges. The bench's memory model registers its read data on the strobe edge and changes reset only on the falling clock edge, so both assumptions hold throughout the run.

Nothing is assumed about start or the sampled inputs while an operation runs. The stimulus deliberately scrambles the address, operation, mode and carry right after every start, and it holds start high across a busy interval. Both are done to show that those inputs are taken only once.

// File: rtl/rmw_shift_pkg.sv
package rmw_shift_pkg;

  localparam int unsigned WORD_W = 8;

  typedef enum logic [1:0] {
    OP_SHL = 2'd0,
    OP_SHR = 2'd1,
    OP_ROL = 2'd2,
    OP_ROR = 2'd3
  } shift_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPT,
    ST_DUMMY,
    ST_FINAL,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic neg;
  } flag_t;

  // Returns {carry_out, result}
  function automatic logic [WORD_W:0] shift_calc(shift_op_e op, logic [WORD_W-1:0] v, logic cin);
    case (op)
      OP_SHL:  return {v[WORD_W-1], v[WORD_W-2:0], 1'b0};
      OP_SHR:  return {v[0], 1'b0, v[WORD_W-1:1]};
      OP_ROL:  return {v[WORD_W-1], v[WORD_W-2:0], cin};
      OP_ROR:  return {v[0], cin, v[WORD_W-1:1]};
      default: return '0;
    endcase
  endfunction

  function automatic flag_t flags_of(logic cout, logic [WORD_W-1:0] r);
    flag_t f;
    f.carry = cout;
    f.zero  = (r == '0);
    f.neg   = r[WORD_W-1];
    return f;
  endfunction

endpackage

// File: rtl/rmw_shift_ctrl.sv
module rmw_shift_ctrl
  import rmw_shift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic legacy_i,
  output logic accept_o,
  output logic read_o,
  output logic capt_o,
  output logic dummy_o,
  output logic final_o,
  output logic done_o,
  output logic idle_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_READ;
      ST_READ:  state_d = ST_CAPT;
      ST_CAPT:  state_d = legacy_i ? ST_DUMMY : ST_FINAL;
      ST_DUMMY: state_d = ST_FINAL;
      ST_FINAL: state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = idle_o && start_i;
  assign read_o   = (state_q == ST_READ);
  assign capt_o   = (state_q == ST_CAPT);
  assign dummy_o  = (state_q == ST_DUMMY);
  assign final_o  = (state_q == ST_FINAL);
  assign done_o   = (state_q == ST_DONE);

endmodule

// File: rtl/rmw_shift_dp.sv
module rmw_shift_dp
  import rmw_shift_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              capt_i,
  input  logic              dummy_i,
  input  logic              final_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        op_i,
  input  logic              legacy_i,
  input  logic              carry_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic              legacy_q_o,
  output flag_t             flags_o
);

  logic [ADDR_W-1:0] addr_q;
  shift_op_e         op_q;
  logic              legacy_q;
  logic              cin_q;
  logic [WORD_W-1:0] opnd_q;
  flag_t             flags_q;
  logic [WORD_W:0]   calc_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      op_q     <= OP_SHL;
      legacy_q <= 1'b0;
      cin_q    <= 1'b0;
    end else if (accept_i) begin
      addr_q   <= addr_i;
      op_q     <= shift_op_e'(op_i);
      legacy_q <= legacy_i;
      cin_q    <= carry_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      opnd_q <= '0;
    else if (capt_i) opnd_q <= rdata_i;
  end

  assign calc_w = shift_calc(op_q, opnd_q, cin_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (final_i) flags_q <= flags_of(calc_w[WORD_W], calc_w[WORD_W-1:0]);
  end

  assign addr_o     = addr_q;
  assign wdata_o    = dummy_i ? opnd_q : calc_w[WORD_W-1:0];
  assign legacy_q_o = legacy_q;
  assign flags_o    = flags_q;

endmodule

// File: rtl/rmw_shift_seq.sv
module rmw_shift_seq
  import rmw_shift_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              legacy_bus_i,
  input  logic              carry_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_re_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_we_o,
  output logic [7:0]        mem_wdata_o,
  output logic              done_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o
);

  logic  accept_w, read_w, capt_w, dummy_wr_w, final_wr_w, done_w, idle_w;
  logic  legacy_q_w;
  flag_t flags_w;

  rmw_shift_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .legacy_i (legacy_q_w),
    .accept_o (accept_w),
    .read_o   (read_w),
    .capt_o   (capt_w),
    .dummy_o  (dummy_wr_w),
    .final_o  (final_wr_w),
    .done_o   (done_w),
    .idle_o   (idle_w)
  );

  rmw_shift_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .capt_i     (capt_w),
    .dummy_i    (dummy_wr_w),
    .final_i    (final_wr_w),
    .addr_i     (addr_i),
    .op_i       (op_i),
    .legacy_i   (legacy_bus_i),
    .carry_i    (carry_i),
    .rdata_i    (mem_rdata_i),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .legacy_q_o (legacy_q_w),
    .flags_o    (flags_w)
  );

  assign mem_re_o = read_w;
  assign mem_we_o = dummy_wr_w | final_wr_w;
  assign done_o   = done_w;
  assign carry_o  = flags_w.carry;
  assign zero_o   = flags_w.zero;
  assign neg_o    = flags_w.neg;

endmodule

// File: rtl/rmw_shift_chk.sv
module rmw_shift_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_re,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              done,
  input logic              zero,
  input logic              neg,
  input logic              idle,
  input logic              dummy_wr,
  input logic              final_wr,
  input logic              legacy_q
);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));

  a_r10_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> !mem_re);

  a_r11_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$past(idle)) |-> $stable(mem_addr));

  a_r7_dummy_then_final: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_wr |=> (final_wr && $stable(mem_addr)));

  a_r7_dummy_only_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    dummy_wr |-> legacy_q);

  a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (final_wr && !legacy_q) |-> !$past(mem_we));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(final_wr));

  a_r6_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((zero == ($past(mem_wdata) == 8'h00)) && (neg == $past(mem_wdata[7]))));

endmodule

bind rmw_shift_seq rmw_shift_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_re    (mem_re_o),
  .mem_we    (mem_we_o),
  .mem_addr  (mem_addr_o),
  .mem_wdata (mem_wdata_o),
  .done      (done_o),
  .zero      (zero_o),
  .neg       (neg_o),
  .idle      (idle_w),
  .dummy_wr  (dummy_wr_w),
  .final_wr  (final_wr_w),
  .legacy_q  (legacy_q_w)
);

// File: tb/test_rmw_shift_seq.sv
`timescale 1ns/1ps
module test_rmw_shift_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'd0;
  logic        legacy_bus_i = 1'b0;
  logic        carry_i = 1'b0;
  logic [15:0] addr_i = 16'd0;
  logic [15:0] mem_addr_o;
  logic        mem_re_o, mem_we_o, done_o, carry_o, zero_o, neg_o;
  logic [7:0]  mem_rdata_i = 8'd0;
  logic [7:0]  mem_wdata_o;

  always #4 clk = ~clk;

  rmw_shift_seq i_rmw_shift_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .legacy_bus_i(legacy_bus_i), .carry_i(carry_i), .addr_i(addr_i),
    .mem_addr_o(mem_addr_o), .mem_re_o(mem_re_o), .mem_rdata_i(mem_rdata_i),
    .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .done_o(done_o),
    .carry_o(carry_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  // bench memory with access log
  logic [7:0]  mem [16];
  logic        poke_en = 1'b0, log_clr = 1'b0;
  logic [3:0]  poke_a = 4'd0;
  logic [7:0]  poke_d = 8'd0;
  logic [15:0] exp_addr = 16'd0;
  int          we_cnt = 0, re_cnt = 0;
  logic [7:0]  wd0 = 8'd0, wd1 = 8'd0;
  bit          addr_bad = 1'b0, order_bad = 1'b0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    if (log_clr) begin
      we_cnt <= 0; re_cnt <= 0; addr_bad <= 1'b0; order_bad <= 1'b0;
    end else begin
      if (mem_re_o) begin
        mem_rdata_i <= mem[mem_addr_o[3:0]];
        re_cnt <= re_cnt + 1;
        if (mem_addr_o != exp_addr) addr_bad <= 1'b1;
      end
      if (mem_we_o) begin
        mem[mem_addr_o[3:0]] <= mem_wdata_o;
        if (we_cnt == 0) wd0 <= mem_wdata_o;
        if (we_cnt == 1) wd1 <= mem_wdata_o;
        we_cnt <= we_cnt + 1;
        if (mem_addr_o != exp_addr) addr_bad <= 1'b1;
        if (re_cnt == 0) order_bad <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns carry*256 + result, computed arithmetically
  function automatic int model(int op, int v, int cin);
    int r, c;
    case (op)
      0: begin r = (v * 2) % 256;       c = v / 128; end
      1: begin r = v / 2;               c = v % 2;   end
      2: begin r = (v * 2) % 256 + cin; c = v / 128; end
      default: begin r = v / 2 + 128 * cin; c = v % 2; end
    endcase
    return c * 256 + r;
  endfunction

  task automatic poke(input int a, input int v);
    poke_en = 1'b1; poke_a = a[3:0]; poke_d = v[7:0];
    tick();
    poke_en = 1'b0;
  endtask

  task automatic check_idle(input string req);
    chk(mem_re_o == 1'b0 && mem_we_o == 1'b0, req, {mem_re_o, mem_we_o}, 0);
    chk(done_o == 1'b0, req, done_o, 0);
    chk({carry_o, zero_o, neg_o} == 3'b000, req, {carry_o, zero_o, neg_o}, 0);
  endtask

  task automatic do_op(input int a, input int v, input int op, input int leg, input int cin);
    int lat, m, res, c, exp_lat;
    string rq;
    rq = (op == 0) ? "R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
    m = model(op, v, cin);
    res = m % 256;
    c = m / 256;
    exp_lat = leg ? 5 : 4;
    exp_addr = a[15:0];
    log_clr = 1'b1;
    poke(a, v);
    log_clr = 1'b0;
    addr_i = a[15:0]; op_i = op[1:0]; legacy_bus_i = leg[0]; carry_i = cin[0];
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    // R11: scramble sampled inputs after start
    addr_i = a[15:0] ^ 16'h0005; op_i = ~op[1:0]; legacy_bus_i = ~leg[0]; carry_i = ~cin[0];
    lat = 1;
    while (!done_o && lat < 20) begin
      tick();
      lat++;
    end
    chk(lat == exp_lat, leg ? "R7 latency" : "R8 latency", lat, exp_lat);
    chk(mem[a[3:0]] == res[7:0], rq, mem[a[3:0]], res);
    chk(carry_o == c[0], rq, carry_o, c);
    chk(zero_o == (res == 0), "R6 zero", zero_o, res == 0);
    chk(neg_o == (res >= 128), "R6 neg", neg_o, res >= 128);
    chk(we_cnt == (leg ? 2 : 1), leg ? "R7 writes" : "R8 writes", we_cnt, leg ? 2 : 1);
    chk(re_cnt == 1, "R10 reads", re_cnt, 1);
    if (leg) begin
      chk(wd0 == v[7:0], "R7 dummy data", wd0, v);
      chk(wd1 == res[7:0], "R7 final data", wd1, res);
    end else begin
      chk(wd0 == res[7:0], "R8 final data", wd0, res);
    end
    chk(!addr_bad, "R10 R11 address", addr_bad, 0);
    chk(!order_bad, "R7 read first", order_bad, 0);
    tick();
    chk(done_o == 1'b0, "R9 done pulse", done_o, 0);
    chk(carry_o == c[0] && zero_o == (res == 0), "R9 flags held", carry_o, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    tick(); tick();
    check_idle("R1 in reset");
    rst_n = 1'b1;
    tick();
    check_idle("R1 after reset");

    // sweep: mode x op x carry x operand
    for (int leg = 0; leg < 2; leg++)
      for (int op = 0; op < 4; op++)
        for (int cin = 0; cin < 2; cin++)
          for (int v = 0; v < 256; v++)
            do_op(v % 16, v, op, leg, cin);

    // R11: start held high while busy is ignored
    poke(9, 8'h5A);
    exp_addr = 16'd3;
    log_clr = 1'b1;
    poke(3, 8'h81);
    log_clr = 1'b0;
    addr_i = 16'd3; op_i = 2'd0; legacy_bus_i = 1'b0; carry_i = 1'b0;
    start_i = 1'b1;
    tick();
    addr_i = 16'd9; op_i = 2'd3; carry_i = 1'b1;
    tick(); tick();
    start_i = 1'b0;
    tick();
    chk(done_o == 1'b1, "R11 done", done_o, 1);
    tick(); tick(); tick();
    chk(mem[9] == 8'h5A, "R11 busy start ignored", mem[9], 8'h5A);
    chk(mem[3] == 8'h02, "R11 first op result", mem[3], 8'h02);
    chk(we_cnt == 1, "R11 single op", we_cnt, 1);

    // R1: reset in the middle of a legacy operation
    exp_addr = 16'd7;
    log_clr = 1'b1;
    poke(7, 8'hC3);
    log_clr = 1'b0;
    addr_i = 16'd7; op_i = 2'd2; legacy_bus_i = 1'b1; carry_i = 1'b1;
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    tick(); tick();
    chk(mem_we_o == 1'b1, "R7 dummy cycle", mem_we_o, 1);
    rst_n = 1'b0;
    tick();
    check_idle("R1 mid-op reset");
    rst_n = 1'b1;
    tick(); tick();
    check_idle("R1 stays idle");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule